// File: doc/BRIEF.md
# Multicast Scatter Tree Controller

This block distributes flits from a shared buffer port to an array of processing elements through a binary scatter tree. Each incoming flit comes with a destination mask holding one bit per PE. A set bit marks that PE as a recipient, so a single flit can be a unicast, a multicast or a broadcast. The mask is reduced level by level with OR gates into a pair of branch enables for every branching node of the tree. A node passes the flit to a child only when that child's subtree holds at least one destination. Bits beyond the PE count are padded with zeros up to the next power of two.

The branch enables and the flit payload are loaded into registers in the cycle the flit is accepted. In the following cycle the flit crosses the tree from root to leaves with no buffering. The configuration of the next flit therefore overlaps the traversal of the current one, and one flit can be accepted every cycle. The controller keeps one credit counter per PE input buffer. It accepts a flit only when every addressed PE has a free slot, and on acceptance it takes one credit from each addressed PE. PEs hand slots back with one-cycle credit pulses, and each counter saturates at its depth.

A two-state machine tracks the tree stage. S_IDLE means no flit is in the tree; S_SEND means a flit is crossing it this cycle. The transition S_IDLE to S_SEND and the S_SEND self-loop happen on acceptance. S_SEND returns to S_IDLE on a cycle with no acceptance, and S_IDLE stays in S_IDLE the same way.

Top module: `scatter_tree_ctrl`

## Requirements
- R1: `in_ready` is high exactly when every PE whose bit is set in `in_mask` (bit i addresses PE i) holds at least one credit; after reset every PE holds `CREDIT_DEPTH` credits.
- R2: A flit accepted at a clock edge (`in_valid` and `in_ready` high) drives `pe_valid` equal to its mask during the next cycle. Each addressed PE's data slice (`pe_data[i*DATA_W +: DATA_W]`) carries the flit payload.
- R3: During traversal, a PE that is not addressed keeps its valid low and its data slice at zero.
- R4: Flits accepted on consecutive edges appear on consecutive cycles, each with its own mask and data, with no bubble. A cycle that follows an edge with no acceptance shows all `pe_valid` low.
- R5: A flit with an all-zero mask is accepted (ready high) and drives no `pe_valid`.
- R6: Each acceptance removes one credit from every addressed PE. A flit that addresses a PE with zero credits is held off: ready stays low, nothing is issued and no other PE's credit is consumed.
- R7: A credit pulse on `pe_credit[i]` returns one credit to PE i, up to `CREDIT_DEPTH`. Pulses that arrive while the count is full are ignored.
- R8: A credit return and an issue to the same PE on the same edge leave that PE's count unchanged.
- R9: After reset no `pe_valid` is asserted and the tree is in S_IDLE.
- R10: With a PE count that is not a power of two, the tree is built for the next power of two with the extra leaves never enabled, and the PE outputs follow the mask exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Buffer-side flit present |
| in_ready | output | 1 | Flit may be accepted this cycle |
| in_mask | input | NUM_PE | Destination mask, bit i addresses PE i |
| in_data | input | DATA_W | Flit payload |
| pe_valid | output | NUM_PE | Per-PE flit valid during traversal |
| pe_data | output | NUM_PE*DATA_W | Per-PE payload, slice i for PE i, zero when not addressed |
| pe_credit | input | NUM_PE | One-cycle credit return pulse per PE |

## Verification
The hardest states to reach from the ports are the credit boundaries. These are a PE that receives extra return pulses while its count is already full, and a PE that gets an issue and a return on the same edge. Neither shows up directly; each only changes how many later flits to that PE are accepted before ready falls. The stimulus first issues flits to drain a chosen PE's credits or leaves them full. It then applies return pulses alone or together with an acceptance, and afterwards counts how many flits to that PE are accepted before `in_ready` drops. A second instance with five PEs receives the same vector table to exercise the zero padding.

// File: rtl/scat_pkg.sv
package scat_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } tree_state_e;
endpackage

// File: rtl/scat_mask_reduce.sv
module scat_mask_reduce #(
    parameter int NUM_PE = 8,
    localparam int LEVELS = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int PADDED = 1 << LEVELS,
    localparam int EN_W   = 2 * PADDED - 2
) (
    input  logic [NUM_PE-1:0] mask,
    output logic [EN_W-1:0]   branch_en
);
    logic [PADDED-1:0] padded;

    always_comb begin
        padded = '0;
        padded[NUM_PE-1:0] = mask;
    end

    // Child level c holds 2^c enables at offset 2^c-2; each covers PADDED>>c leaves.
    for (genvar c = 1; c <= LEVELS; c++) begin : g_level
        localparam int SPAN = PADDED >> c;
        for (genvar j = 0; j < (1 << c); j++) begin : g_node
            assign branch_en[(1 << c) - 2 + j] = |padded[j*SPAN +: SPAN];
        end
    end
endmodule

// File: rtl/scat_tree_fabric.sv
module scat_tree_fabric #(
    parameter int NUM_PE = 8,
    parameter int DATA_W = 16,
    localparam int LEVELS = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int PADDED = 1 << LEVELS,
    localparam int EN_W   = 2 * PADDED - 2
) (
    input  logic                     root_go,
    input  logic [EN_W-1:0]          branch_en,
    input  logic [DATA_W-1:0]        flit,
    output logic [NUM_PE-1:0]        leaf_valid,
    output logic [NUM_PE*DATA_W-1:0] leaf_data
);
    // reach: node at level c, index j, sits at 2^c-1+j
    logic [2*PADDED-2:0] reach;

    assign reach[0] = root_go;

    for (genvar c = 1; c <= LEVELS; c++) begin : g_level
        for (genvar j = 0; j < (1 << c); j++) begin : g_node
            assign reach[(1 << c) - 1 + j] =
                reach[(1 << (c - 1)) - 1 + j / 2] & branch_en[(1 << c) - 2 + j];
        end
    end

    for (genvar i = 0; i < NUM_PE; i++) begin : g_leaf
        assign leaf_valid[i] = reach[PADDED - 1 + i];
        assign leaf_data[i*DATA_W +: DATA_W] = reach[PADDED - 1 + i] ? flit : '0;
    end

    if (PADDED > NUM_PE) begin : g_pad
        logic pad_unused;
        assign pad_unused = |reach[2*PADDED-2 : PADDED-1+NUM_PE];
    end
endmodule

// File: rtl/scat_credit_bank.sv
module scat_credit_bank #(
    parameter int NUM_PE       = 8,
    parameter int CREDIT_DEPTH = 2,
    localparam int CW = $clog2(CREDIT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PE-1:0] take,
    input  logic [NUM_PE-1:0] give,
    output logic [NUM_PE-1:0] has_slot
);
    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= CW'(CREDIT_DEPTH);
            end else begin
                unique case ({take[i], give[i]})
                    2'b10:   cnt <= cnt - 1'b1;
                    2'b01:   if (cnt != CW'(CREDIT_DEPTH)) cnt <= cnt + 1'b1;
                    default: cnt <= cnt;
                endcase
            end
        end

        assign has_slot[i] = (cnt != '0);

        // R7: the count never exceeds its depth
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(CREDIT_DEPTH));

        // R6: nothing is taken from an empty counter
        p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            take[i] |-> cnt != '0);
    end
endmodule

// File: rtl/scatter_tree_ctrl.sv
module scatter_tree_ctrl #(
    parameter int NUM_PE       = 8,
    parameter int DATA_W       = 16,
    parameter int CREDIT_DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [NUM_PE-1:0]        in_mask,
    input  logic [DATA_W-1:0]        in_data,
    output logic [NUM_PE-1:0]        pe_valid,
    output logic [NUM_PE*DATA_W-1:0] pe_data,
    input  logic [NUM_PE-1:0]        pe_credit
);
    import scat_pkg::*;

    localparam int LEVELS = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;
    localparam int PADDED = 1 << LEVELS;
    localparam int EN_W   = 2 * PADDED - 2;

    tree_state_e         state, state_nx;
    logic [NUM_PE-1:0]   has_slot;
    logic [NUM_PE-1:0]   take;
    logic                fire;
    logic                root_go;
    logic [EN_W-1:0]     en_d, en_q;
    logic [DATA_W-1:0]   data_q;

    assign in_ready = &(~in_mask | has_slot);
    assign fire     = in_valid & in_ready;
    assign take     = fire ? in_mask : '0;

    scat_mask_reduce #(.NUM_PE(NUM_PE)) u_reduce (
        .mask      (in_mask),
        .branch_en (en_d)
    );

    scat_credit_bank #(.NUM_PE(NUM_PE), .CREDIT_DEPTH(CREDIT_DEPTH)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .give     (pe_credit),
        .has_slot (has_slot)
    );

    // configuration registers, loaded one cycle ahead of traversal
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            data_q <= '0;
        end else if (fire) begin
            en_q   <= en_d;
            data_q <= in_data;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  state_nx = fire ? S_SEND : S_IDLE;
            S_SEND:  state_nx = fire ? S_SEND : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // output process
    always_comb begin
        root_go = 1'b0;
        unique case (state)
            S_IDLE:  root_go = 1'b0;
            S_SEND:  root_go = 1'b1;
            default: root_go = 1'b0;
        endcase
    end

    scat_tree_fabric #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_fabric (
        .root_go    (root_go),
        .branch_en  (en_q),
        .flit       (data_q),
        .leaf_valid (pe_valid),
        .leaf_data  (pe_data)
    );

    // R2: the leaves reached next cycle are exactly the accepted mask
    p_leaf_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pe_valid == $past(in_mask));

    // R4: no acceptance, no traffic in the following cycle
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> pe_valid == '0);
endmodule

// File: tb/sim_scatter_tree_ctrl.sv
module sim_scatter_tree_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int N1 = 5;
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {8'h01, 16'hA001}, {8'h80, 16'hB080}, {8'hFF, 16'hC0FF},
        {8'h55, 16'hD055}, {8'hAA, 16'hE0AA}, {8'h18, 16'hF018},
        {8'h3C, 16'h1234}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [N-1:0] in_mask = '0;
    logic [W-1:0] in_data = '0;
    logic [N-1:0] pe_valid;
    logic [N*W-1:0] pe_data;
    logic [N-1:0] pe_credit = '0;

    logic u1_valid = 1'b0;
    logic u1_ready;
    logic [N1-1:0] u1_mask = '0;
    logic [W-1:0] u1_data = '0;
    logic [N1-1:0] u1_pe_valid;
    logic [N1*W-1:0] u1_pe_data;
    logic [N1-1:0] u1_credit = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scatter_tree_ctrl #(.NUM_PE(N), .DATA_W(W), .CREDIT_DEPTH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask(in_mask), .in_data(in_data), .pe_valid(pe_valid),
        .pe_data(pe_data), .pe_credit(pe_credit)
    );

    scatter_tree_ctrl #(.NUM_PE(N1), .DATA_W(W), .CREDIT_DEPTH(2)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(u1_valid), .in_ready(u1_ready),
        .in_mask(u1_mask), .in_data(u1_data), .pe_valid(u1_pe_valid),
        .pe_data(u1_pe_data), .pe_credit(u1_credit)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // outputs of the traversal cycle against a mask and payload
    task automatic check_out(input logic [N-1:0] m, input logic [W-1:0] d, input string req);
        check(pe_valid == m, req, 64'(pe_valid), 64'(m));
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] e;
            e = m[i] ? d : '0;
            check(pe_data[i*W +: W] == e, m[i] ? "R2 data" : "R3 unaddressed data",
                  64'(pe_data[i*W +: W]), 64'(e));
        end
    endtask

    task automatic send(input logic [N-1:0] m, input logic [W-1:0] d, input string req);
        tick();
        in_valid = 1'b1; in_mask = m; in_data = d;
        #1 check(in_ready == 1'b1, req, 64'(in_ready), 64'd1);
        tick();
        in_valid = 1'b0;
        check_out(m, d, req);
    endtask

    task automatic give(input logic [N-1:0] m);
        tick();
        pe_credit = m;
        tick();
        pe_credit = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 / R1 reset state
        in_mask = '1;
        #1;
        check(pe_valid == '0, "R9 no valid after reset", 64'(pe_valid), 64'd0);
        check(in_ready == 1'b1, "R1 full credits after reset", 64'(in_ready), 64'd1);

        // vector table, both instances; R10 via the five-PE instance
        foreach (VEC[k]) begin
            logic [N-1:0] m;
            logic [W-1:0] d;
            m = VEC[k][23:16];
            d = VEC[k][15:0];
            tick();
            in_valid = 1'b1; in_mask = m; in_data = d;
            u1_valid = 1'b1; u1_mask = m[N1-1:0]; u1_data = d;
            #1 check(in_ready == 1'b1, "R1 ready with credits", 64'(in_ready), 64'd1);
            tick();
            in_valid = 1'b0; u1_valid = 1'b0;
            check_out(m, d, "R2 table mask");
            check(u1_pe_valid == m[N1-1:0], "R10 padded tree valid",
                  64'(u1_pe_valid), 64'(m[N1-1:0]));
            check(u1_pe_data[4*W +: W] == (m[4] ? d : '0), "R10 padded tree data",
                  64'(u1_pe_data[4*W +: W]), 64'(m[4] ? d : '0));
            pe_credit = m; u1_credit = m[N1-1:0];
            tick();
            pe_credit = '0; u1_credit = '0;
            check(pe_valid == '0, "R4 idle after lone flit", 64'(pe_valid), 64'd0);
        end

        // R4 back-to-back
        tick();
        in_valid = 1'b1; in_mask = 8'h0F; in_data = 16'h1111;
        tick();
        check_out(8'h0F, 16'h1111, "R4 back-to-back first");
        in_mask = 8'hF0; in_data = 16'h2222;
        tick();
        check_out(8'hF0, 16'h2222, "R4 back-to-back second");
        in_mask = 8'h81; in_data = 16'h3333;
        tick();
        check_out(8'h81, 16'h3333, "R4 back-to-back third");
        in_valid = 1'b0;
        in_mask = 8'h01;
        #1 check(in_ready == 1'b0, "R6 drained PE0 blocks", 64'(in_ready), 64'd0);
        in_mask = 8'h02;
        #1 check(in_ready == 1'b1, "R1 PE1 still has credit", 64'(in_ready), 64'd1);
        give(8'hFF);
        give(8'h81);

        // R8 simultaneous issue and return on PE2
        send(8'h04, 16'h4444, "R2 first to PE2");
        tick();
        in_valid = 1'b1; in_mask = 8'h04; in_data = 16'h4445; pe_credit = 8'h04;
        #1 check(in_ready == 1'b1, "R8 ready at overlap", 64'(in_ready), 64'd1);
        tick();
        pe_credit = '0; in_data = 16'h4446;
        #1 check(in_ready == 1'b1, "R8 count kept after overlap", 64'(in_ready), 64'd1);
        tick();
        in_valid = 1'b0;
        #1 check(in_ready == 1'b0, "R8 PE2 now empty", 64'(in_ready), 64'd0);
        give(8'h04);
        give(8'h04);

        // R7 saturation on PE5
        give(8'h20);
        give(8'h20);
        give(8'h20);
        send(8'h20, 16'h5551, "R7 first after extra pulses");
        send(8'h20, 16'h5552, "R7 second after extra pulses");
        in_mask = 8'h20;
        #1 check(in_ready == 1'b0, "R7 extra pulses ignored", 64'(in_ready), 64'd0);
        give(8'h20);
        give(8'h20);

        // R5 all-zero mask
        tick();
        in_valid = 1'b1; in_mask = 8'h00; in_data = 16'hBEEF;
        #1 check(in_ready == 1'b1, "R5 zero mask accepted", 64'(in_ready), 64'd1);
        tick();
        in_valid = 1'b0;
        check_out(8'h00, 16'h0000, "R5 zero mask no valid");

        // R6 hold-off on PE3 with PE2 also addressed
        send(8'h08, 16'h6661, "R6 drain PE3 a");
        send(8'h08, 16'h6662, "R6 drain PE3 b");
        tick();
        in_valid = 1'b1; in_mask = 8'h0C; in_data = 16'h7777;
        #1 check(in_ready == 1'b0, "R6 held off", 64'(in_ready), 64'd0);
        tick();
        check(pe_valid == '0, "R6 nothing issued", 64'(pe_valid), 64'd0);
        pe_credit = 8'h08;
        #1 check(in_ready == 1'b0, "R6 still held during return", 64'(in_ready), 64'd0);
        tick();
        pe_credit = '0;
        #1 check(in_ready == 1'b1, "R7 return reopens PE3", 64'(in_ready), 64'd1);
        tick();
        in_valid = 1'b0;
        check_out(8'h0C, 16'h7777, "R6 issued after return");
        in_mask = 8'h04;
        #1 check(in_ready == 1'b1, "R6 PE2 credit kept while held", 64'(in_ready), 64'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule